// File: doc/BRIEF.md
# Static-Pattern Vector Shuffle Unit

This block reorders the elements of short vectors using a handful of permutations that are fixed when the chip is built. It does not contain a runtime-indexed crossbar. Each output lane takes its data from a constant set of input lanes, so the logic grows roughly linearly with the lane count. A vector trigger selects one of four permutations of two source vectors, or a broadcast of a scalar into every lane. The result is registered and stays in place until the next accepted vector operation.

The permutations serve windowed image kernels:

- **One-element shift** steps an aligned load to the next convolution window.
- **Two-element shift** skips two windows.
- **Even-element decimation** halves the resolution.
- **Four-element interleave** merges two pixel streams in blocks of four.

A separate extract path has its own trigger. It reads one lane of the first source vector, chosen by a scalar index, and delivers it zero-extended to the scalar width. Both paths can be triggered in the same cycle.

Top module: `vec_shuffle_static`

## Requirements
- R1: While reset is asserted, and after it is released, `vec_out` and `scal_out` are all zeros and `vec_vld` and `scal_vld` are low until an operation is triggered.
- R2: Opcode 0 (one-element shift): output lane i equals `vec_a` lane i+1 for i < N-1, and lane N-1 equals `vec_b` lane 0. Lane 0 sits in the least significant bits of each vector port.
- R3: Opcode 1 (two-element shift): output lane i equals `vec_a` lane i+2 for i < N-2. Lanes N-2 and N-1 equal `vec_b` lanes 0 and 1.
- R4: Opcode 2 (decimation): output lane i equals `vec_a` lane 2i for i < N/2, and output lane N/2+i equals `vec_b` lane 2i.
- R5: Opcode 3 (four-element interleave): for every j, output lanes 8j..8j+3 equal `vec_a` lanes 4j..4j+3, and output lanes 8j+4..8j+7 equal `vec_b` lanes 4j..4j+3.
- R6: Opcode 4 (broadcast): every output lane equals the low element-width bits of `scalar_in`.
- R7: Opcodes 5, 6 and 7 are ignored. `vec_out` keeps its value and `vec_vld` stays low.
- R8: An accepted vector operation updates `vec_out` on the clock edge that samples `op_go`, and `vec_vld` is high for exactly that following cycle. Without an accepted operation, `vec_out` holds.
- R9: When `ext_go` is high, `scal_out` becomes `vec_a` lane (`ext_idx` mod N), zero-extended, on the next edge, and `scal_vld` pulses for that one cycle. This happens independently of any vector operation in the same cycle.
- R10: Without `ext_go`, `scal_out` holds its value. Vector operations never change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_go | input | 1 | Vector operation trigger |
| op_sel | input | 3 | Vector opcode (0 to 4 valid) |
| vec_a | input | LANES*ELEM_W | First source vector, lane 0 in the least significant bits |
| vec_b | input | LANES*ELEM_W | Second source vector |
| scalar_in | input | SCALAR_W | Scalar operand for broadcast |
| ext_go | input | 1 | Extract trigger |
| ext_idx | input | IDX_W | Lane index for extract, taken mod LANES |
| vec_out | output | LANES*ELEM_W | Registered vector result |
| vec_vld | output | 1 | One-cycle pulse after an accepted vector operation |
| scal_out | output | SCALAR_W | Registered, zero-extended extracted element |
| scal_vld | output | 1 | One-cycle pulse after an extract |

## Verification
The vector path (a permutation or a broadcast) and the extract path can fire in the same cycle, and both read `vec_a`. The bench drives `op_go` and `ext_go` together in directed steps and in a long random phase where each trigger is drawn independently. A behavioural model holds the two source vectors in one queue and predicts both registers every clock. It flags any case where one path's result lands in, or disturbs, the other's output.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    OP_SHL1  = 3'd0,
    OP_SHL2  = 3'd1,
    OP_DECIM = 3'd2,
    OP_ILV4  = 3'd3,
    OP_BCAST = 3'd4
  } shf_op_e;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd4;
  endfunction
endpackage

// File: rtl/shf_rst_sync.sv
module shf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/shf_perm.sv
// Constant-index permutation network: every lane picks from a fixed
// handful of sources chosen at elaboration time.
module shf_perm
  import shf_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ELEM_W = 8
) (
  input  logic [LANES*ELEM_W-1:0] src_a,
  input  logic [LANES*ELEM_W-1:0] src_b,
  input  logic [ELEM_W-1:0]       bcast_elem,
  input  logic [2:0]              op,
  output logic [LANES*ELEM_W-1:0] perm_out
);
  localparam int HALF = LANES / 2;

  logic [ELEM_W-1:0] a_l [LANES];
  logic [ELEM_W-1:0] b_l [LANES];

  for (genvar u = 0; u < LANES; u++) begin : g_unpack
    assign a_l[u] = src_a[u*ELEM_W +: ELEM_W];
    assign b_l[u] = src_b[u*ELEM_W +: ELEM_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int GRP = i / 4;
    localparam int POS = i % 4;
    logic [ELEM_W-1:0] sh1, sh2, dec, ilv, sel;

    if (i < LANES - 1) begin : g_s1a
      assign sh1 = a_l[i+1];
    end else begin : g_s1b
      assign sh1 = b_l[0];
    end

    if (i < LANES - 2) begin : g_s2a
      assign sh2 = a_l[i+2];
    end else begin : g_s2b
      assign sh2 = b_l[i-(LANES-2)];
    end

    if (i < HALF) begin : g_dca
      assign dec = a_l[2*i];
    end else begin : g_dcb
      assign dec = b_l[2*(i-HALF)];
    end

    if ((GRP % 2) == 0) begin : g_ila
      assign ilv = a_l[4*(GRP/2)+POS];
    end else begin : g_ilb
      assign ilv = b_l[4*(GRP/2)+POS];
    end

    always_comb begin
      case (op)
        OP_SHL1:  sel = sh1;
        OP_SHL2:  sel = sh2;
        OP_DECIM: sel = dec;
        OP_ILV4:  sel = ilv;
        OP_BCAST: sel = bcast_elem;
        default:  sel = '0;
      endcase
    end

    assign perm_out[i*ELEM_W +: ELEM_W] = sel;
  end
endmodule

// File: rtl/shf_extract.sv
module shf_extract #(
  parameter int LANES    = 8,
  parameter int ELEM_W   = 8,
  parameter int SCALAR_W = 32,
  parameter int IDX_W    = 8
) (
  input  logic [LANES*ELEM_W-1:0] src_a,
  input  logic [IDX_W-1:0]        idx,
  output logic [SCALAR_W-1:0]     elem_out
);
  localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [ELEM_W-1:0] a_l [LANES];
  logic [SELW-1:0]   lane_sel;
  logic              unused_idx_hi;

  for (genvar u = 0; u < LANES; u++) begin : g_unpack
    assign a_l[u] = src_a[u*ELEM_W +: ELEM_W];
  end

  // Power-of-two lane count: modulo is the low index bits.
  assign lane_sel      = idx[SELW-1:0];
  assign unused_idx_hi = ^idx[IDX_W-1:SELW];
  assign elem_out      = {{(SCALAR_W-ELEM_W){1'b0}}, a_l[lane_sel]};
endmodule

// File: rtl/vec_shuffle_static.sv
module vec_shuffle_static
  import shf_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int ELEM_W   = 8,
  parameter int SCALAR_W = 32,
  parameter int IDX_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_go,
  input  logic [2:0]              op_sel,
  input  logic [LANES*ELEM_W-1:0] vec_a,
  input  logic [LANES*ELEM_W-1:0] vec_b,
  input  logic [SCALAR_W-1:0]     scalar_in,
  input  logic                    ext_go,
  input  logic [IDX_W-1:0]        ext_idx,
  output logic [LANES*ELEM_W-1:0] vec_out,
  output logic                    vec_vld,
  output logic [SCALAR_W-1:0]     scal_out,
  output logic                    scal_vld
);
  localparam int VEC_W = LANES * ELEM_W;

  logic                rst_i;
  logic [VEC_W-1:0]    perm_val;
  logic [SCALAR_W-1:0] ext_val;
  logic                unused_scalar_hi;

  logic                vec_en, scal_en;
  logic [VEC_W-1:0]    vec_d, vec_q;
  logic [SCALAR_W-1:0] scal_d, scal_q;
  logic                vvld_d, vvld_q, svld_d, svld_q;

  shf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  shf_perm #(.LANES(LANES), .ELEM_W(ELEM_W)) u_perm (
    .src_a      (vec_a),
    .src_b      (vec_b),
    .bcast_elem (scalar_in[ELEM_W-1:0]),
    .op         (op_sel),
    .perm_out   (perm_val)
  );

  assign unused_scalar_hi = ^scalar_in[SCALAR_W-1:ELEM_W];

  shf_extract #(
    .LANES(LANES), .ELEM_W(ELEM_W), .SCALAR_W(SCALAR_W), .IDX_W(IDX_W)
  ) u_ext (
    .src_a    (vec_a),
    .idx      (ext_idx),
    .elem_out (ext_val)
  );

  // Next-state logic
  always_comb begin
    vec_en  = op_go && op_known(op_sel);
    scal_en = ext_go;
    vvld_d  = vec_en;
    svld_d  = scal_en;
    vec_d   = perm_val;
    scal_d  = ext_val;
  end

  // State registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      vec_q  <= '0;
      scal_q <= '0;
      vvld_q <= 1'b0;
      svld_q <= 1'b0;
    end else begin
      vvld_q <= vvld_d;
      svld_q <= svld_d;
      if (vec_en)  vec_q  <= vec_d;
      if (scal_en) scal_q <= scal_d;
    end
  end

  assign vec_out  = vec_q;
  assign vec_vld  = vvld_q;
  assign scal_out = scal_q;
  assign scal_vld = svld_q;
endmodule

// File: rtl/vec_shuffle_static_chk.sv
module vec_shuffle_static_chk #(
  parameter int LANES    = 8,
  parameter int ELEM_W   = 8,
  parameter int SCALAR_W = 32,
  parameter int IDX_W    = 8
) (
  input logic                    clk,
  input logic                    rst_i,
  input logic                    op_go,
  input logic [2:0]              op_sel,
  input logic [SCALAR_W-1:0]     scalar_in,
  input logic                    ext_go,
  input logic [LANES*ELEM_W-1:0] vec_out,
  input logic                    vec_vld,
  input logic [SCALAR_W-1:0]     scal_out,
  input logic                    scal_vld
);
  // R8: accepted vector op yields a valid pulse next cycle
  assert_vec_vld_follows_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (op_go && op_sel <= 3'd4) |=> vec_vld);

  // R7: no valid pulse for idle cycles or reserved opcodes
  assert_no_spurious_vld_R7: assert property (@(posedge clk) disable iff (!rst_i)
    !(op_go && op_sel <= 3'd4) |=> !vec_vld);

  // R8: vector result holds without an accepted op
  assert_vec_hold_R8: assert property (@(posedge clk) disable iff (!rst_i)
    !(op_go && op_sel <= 3'd4) |=> $stable(vec_out));

  // R6: broadcast replicates the low scalar bits
  assert_bcast_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (op_go && op_sel == 3'd4) |=> vec_out == {LANES{$past(scalar_in[ELEM_W-1:0])}});

  // R9: extract valid pulse tracks its trigger
  assert_ext_vld_R9: assert property (@(posedge clk) disable iff (!rst_i)
    ext_go |=> scal_vld);

  // R9: extracted value is zero-extended
  assert_ext_zero_ext_R9: assert property (@(posedge clk) disable iff (!rst_i)
    scal_vld |-> scal_out[SCALAR_W-1:ELEM_W] == '0);

  // R10: scalar result holds without an extract
  assert_scal_hold_R10: assert property (@(posedge clk) disable iff (!rst_i)
    !ext_go |=> ($stable(scal_out) && !scal_vld));
endmodule

bind vec_shuffle_static vec_shuffle_static_chk #(
  .LANES(LANES), .ELEM_W(ELEM_W), .SCALAR_W(SCALAR_W), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_i     (rst_i),
  .op_go     (op_go),
  .op_sel    (op_sel),
  .scalar_in (scalar_in),
  .ext_go    (ext_go),
  .vec_out   (vec_out),
  .vec_vld   (vec_vld),
  .scal_out  (scal_out),
  .scal_vld  (scal_vld)
);

// File: tb/vec_shuffle_static_test.sv
module vec_shuffle_static_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 16;
  localparam int EW     = 8;
  localparam int SW     = 32;
  localparam int IW     = 8;
  localparam int VW     = LANES * EW;

  logic          clk, rst_n, op_go, ext_go;
  logic [2:0]    op_sel;
  logic [VW-1:0] vec_a, vec_b, vec_out;
  logic [SW-1:0] scalar_in, scal_out;
  logic [IW-1:0] ext_idx;
  logic          vec_vld, scal_vld;

  vec_shuffle_static #(.LANES(LANES), .ELEM_W(EW), .SCALAR_W(SW), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_sel(op_sel),
    .vec_a(vec_a), .vec_b(vec_b), .scalar_in(scalar_in),
    .ext_go(ext_go), .ext_idx(ext_idx),
    .vec_out(vec_out), .vec_vld(vec_vld), .scal_out(scal_out), .scal_vld(scal_vld)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit chk_on   = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: both sources as one queue of elements.
  function automatic logic [VW-1:0] ref_vector(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                               input int op, input logic [SW-1:0] s);
    logic [EW-1:0] q[$];
    logic [VW-1:0] r;
    for (int k = 0; k < LANES; k++) q.push_back(a[k*EW +: EW]);
    for (int k = 0; k < LANES; k++) q.push_back(b[k*EW +: EW]);
    for (int i = 0; i < LANES; i++) begin
      int g = i / 4;
      int src;
      case (op)
        0: src = i + 1;
        1: src = i + 2;
        2: src = 2 * i;
        default: src = ((g % 2) ? LANES : 0) + 4 * (g / 2) + (i % 4);
      endcase
      r[i*EW +: EW] = (op == 4) ? s[EW-1:0] : q[src];
    end
    return r;
  endfunction

  logic [VW-1:0] exp_vec;
  logic [SW-1:0] exp_scal;
  logic          exp_vvld, exp_svld;
  string         vtag = "R1", stag = "R1";
  int            sync_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n || sync_cnt < 2) begin
      exp_vec = '0; exp_scal = '0; exp_vvld = 0; exp_svld = 0;
      vtag = "R1"; stag = "R1";
      sync_cnt = rst_n ? sync_cnt + 1 : 0;
    end else begin
      exp_vvld = 0;
      if (op_go && op_sel <= 3'd4) begin
        exp_vec  = ref_vector(vec_a, vec_b, int'(op_sel), scalar_in);
        exp_vvld = 1;
        case (op_sel)
          3'd0: vtag = "R2";
          3'd1: vtag = "R3";
          3'd2: vtag = "R4";
          3'd3: vtag = "R5";
          default: vtag = "R6";
        endcase
      end else begin
        vtag = op_go ? "R7" : "R8";
      end
      exp_svld = ext_go;
      if (ext_go) begin
        exp_scal = {{(SW-EW){1'b0}}, vec_a[(int'(ext_idx) % LANES)*EW +: EW]};
        stag = "R9";
      end else begin
        stag = "R10";
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !finished) begin
      n_checks++;
      if (vec_out !== exp_vec || vec_vld !== exp_vvld) begin
        n_fails++;
        $display("FAIL %s vec_out=%h vld=%b expected %h vld=%b", vtag, vec_out, vec_vld, exp_vec, exp_vvld);
      end
      n_checks++;
      if (scal_out !== exp_scal || scal_vld !== exp_svld) begin
        n_fails++;
        $display("FAIL %s scal_out=%h vld=%b expected %h vld=%b", stag, scal_out, scal_vld, exp_scal, exp_svld);
      end
    end
  end

  task automatic drive(input bit go, input int sel, input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic [SW-1:0] s, input bit xg, input int xi);
    @(negedge clk);
    op_go = go; op_sel = 3'(sel); vec_a = a; vec_b = b; scalar_in = s;
    ext_go = xg; ext_idx = IW'(xi);
  endtask

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW; k += 32) v[k +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VW-1:0] ramp(input int base);
    logic [VW-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*EW +: EW] = EW'(base + k);
    return v;
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [VW-1:0] ra, rb;
    rst_n = 1; op_go = 0; op_sel = 0; vec_a = '0; vec_b = '0;
    scalar_in = '0; ext_go = 0; ext_idx = '0;
    #1 rst_n = 0;
    @(posedge clk);
    chk_on = 1;                          // R1: reset state compared every cycle
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) drive(0, 0, '0, '0, '0, 0, 0);
    ra = ramp(8'h10); rb = ramp(8'h80);
    drive(1, 0, ra, rb, '0, 0, 0);       // R2
    drive(1, 1, ra, rb, '0, 0, 0);       // R3
    drive(1, 2, ra, rb, '0, 0, 0);       // R4
    drive(1, 3, ra, rb, '0, 0, 0);       // R5
    drive(1, 4, ra, rb, 32'hDEADBE5A, 0, 0);  // R6
    drive(1, 5, rand_vec(), rand_vec(), '1, 0, 0);  // R7
    drive(1, 6, rand_vec(), rand_vec(), '1, 0, 0);
    drive(1, 7, rand_vec(), rand_vec(), '1, 0, 0);
    drive(0, 0, rand_vec(), rand_vec(), '0, 0, 0);  // R8 hold
    drive(0, 0, ra, rb, '0, 1, 0);       // R9 lane 0
    drive(0, 0, ra, rb, '0, 1, LANES-1);
    drive(0, 0, ra, rb, '0, 1, LANES+3); // R9 modulo
    drive(0, 0, ra, rb, '0, 1, 255);
    drive(1, 0, ra, rb, '0, 0, 0);       // R10 vector op keeps scal_out
    drive(1, 4, ra, rb, 32'h0000_00C3, 1, 7);  // R9 alongside R6
    drive(1, 3, rand_vec(), rand_vec(), '0, 1, 2);
    drive(1, 5, rand_vec(), rand_vec(), '0, 1, 9);
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom % 8;
      drive(($urandom % 4) != 0, sel, rand_vec(), rand_vec(), $urandom,
            ($urandom % 2) == 1, $urandom % 256);
    end
    repeat (3) drive(0, 0, '0, '0, '0, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule